// File: doc/BRIEF.md
# Ring Command Packet Decoder

This block walks a circular command ring of 32-bit words, one word per cycle, from its own read pointer up to a write pointer that the host advances. Each packet starts with a header word. The top four bits select the command, bits 23 and 22 carry two flags, and bits 19:0 carry a count. The operand words that follow are collected, and the command is then carried out. Memory-side work (linear writes, fences, copies, indirect-buffer launches) goes out on a valid-only request port. Register writes go out on a register port. A trap can raise a one-cycle interrupt. The read pointer is exposed at all times for write-back and also addresses the ring storage. The ring storage answers combinationally.

The controller has four states. ST_HDR decodes a header. It goes to ST_ARGS when the command has operands, or stays in ST_HDR for NOP and trap. ST_ARGS gathers operands. On the last operand it goes back to ST_HDR, or to ST_WDATA when a write packet carries data words. ST_WDATA issues one write per data word and returns to ST_HDR after the last one. Any malformed word moves the controller from ST_HDR or ST_ARGS into ST_HALT. ST_HALT is left only by reset.

Top module: `dma_ring_decoder`

## Requirements
- R1: Only opcodes 0x2 (write), 0x3 (copy), 0x4 (indirect buffer), 0x6 (fence), 0x7 (trap), 0x9 (register write) and 0xF (NOP) are accepted, and header bits 27:24 and 21:20 must be zero. Any other header, including opcodes 0x5 and 0xD, halts the block with the error output set.
- R2: The read pointer starts at 0, moves up by one for each consumed word, and wraps at 2^RING_AW. It holds while it equals the write pointer.
- R3: A NOP (0xF) consumes its header word only and produces no output.
- R4: A fence (0x6) takes three operands: address low, address high (bits 7:0), sequence value. It issues one request of kind 2 with that 40-bit address, length 1 and the sequence value as data.
- R5: A write (0x2) takes address low and address high (bits 7:0), then `count` data words. Each data word issues one request of kind 0, length 1, at the base address plus 4 per word. A count of 0 issues nothing.
- R6: A copy (0x3) takes four operands in this order: destination low, source low, destination high, source high. It issues one request of kind 1 with both 40-bit addresses and length equal to the header count.
- R7: An indirect-buffer header (0x4) is accepted only at a ring index equal to 5 mod 8, and its address low word must have bits 4:0 zero. It issues one request of kind 3 with length from operand bits 31:12 and address high from bits 7:0.
- R8: A register write (0x9) takes an address word (byte enables in bits 19:16, offset in bits 15:0) and a data word, and emits them on the register port.
- R9: A trap (0x7) raises irq for one cycle with event code 224 only when trap_en is high at the cycle the trap is consumed.
- R10: An address low word with bits 1:0 nonzero for write, fence, or either copy address halts the block. In any halt, the offending word is not consumed, error stays set and the pointer frozen until reset, and no further output is produced. At most one output strobe is active per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wptr | input | RING_AW | Host write pointer (dword index) |
| trap_en | input | 1 | Enables the trap interrupt |
| ring_data | input | 32 | Ring word at index rptr_wb |
| rptr_wb | output | RING_AW | Current read pointer, also the ring read address |
| req_valid | output | 1 | Memory request strobe |
| req_kind | output | 2 | 0 write, 1 copy, 2 fence, 3 indirect buffer |
| req_flags | output | 2 | Header bits 23 and 22 of the packet |
| req_addr | output | 32+HI_W | Destination or buffer address |
| req_src | output | 32+HI_W | Copy source address, else zero |
| req_len | output | 20 | Length in dwords |
| req_data | output | 32 | Write or fence data, else zero |
| reg_wr_valid | output | 1 | Register write strobe |
| reg_wr_be | output | 4 | Byte enables |
| reg_wr_off | output | 16 | Register offset |
| reg_wr_data | output | 32 | Register data |
| irq | output | 1 | Trap interrupt pulse |
| irq_code | output | 8 | Event code of the last interrupt |
| error | output | 1 | Sticky halt flag |

## Verification
The ring is loaded with packets of every accepted kind. These include a write with three data words and a write with none, which separates per-word address stepping from an empty data phase. They also include non-zero header flags and distinct high address bytes, so that swapped operands show up. A trap with the enable low is followed by a trap with it high. An indirect buffer is placed after NOP padding, and enough traffic is sent to wrap the pointer. Separate runs after reset place an unknown opcode, an indirect buffer at a wrong ring slot, a misaligned fence address and a header with reserved bits set. Each of these must stop the pointer on the offending word and suppress every later packet.

// File: rtl/dmar_pkg.sv
package dmar_pkg;
    localparam logic [3:0] OP_WRITE = 4'h2;
    localparam logic [3:0] OP_COPY  = 4'h3;
    localparam logic [3:0] OP_IB    = 4'h4;
    localparam logic [3:0] OP_FENCE = 4'h6;
    localparam logic [3:0] OP_TRAP  = 4'h7;
    localparam logic [3:0] OP_REGW  = 4'h9;
    localparam logic [3:0] OP_NOP   = 4'hF;

    localparam logic [1:0] RQ_WRITE = 2'd0;
    localparam logic [1:0] RQ_COPY  = 2'd1;
    localparam logic [1:0] RQ_FENCE = 2'd2;
    localparam logic [1:0] RQ_IB    = 2'd3;

    localparam logic [7:0] TRAP_EVENT = 8'd224;
    localparam logic [2:0] IB_SLOT    = 3'd5;

    typedef enum logic [1:0] {ST_HDR, ST_ARGS, ST_WDATA, ST_HALT} st_e;
endpackage

// File: rtl/dmar_hdr.sv
module dmar_hdr
    import dmar_pkg::*;
(
    input  logic [31:0] word,
    output logic [3:0]  op,
    output logic [1:0]  flags,
    output logic [19:0] cnt,
    output logic [2:0]  argc,
    output logic        known
);
    logic op_ok;
    logic rsvd_ok;

    assign op      = word[31:28];
    assign flags   = word[23:22];
    assign cnt     = word[19:0];
    assign rsvd_ok = (word[27:24] == 4'h0) && (word[21:20] == 2'b00);
    assign known   = op_ok && rsvd_ok;

    always_comb begin
        op_ok = 1'b1;
        argc  = 3'd0;
        case (op)
            OP_WRITE: argc = 3'd2;
            OP_COPY:  argc = 3'd4;
            OP_IB:    argc = 3'd2;
            OP_FENCE: argc = 3'd3;
            OP_REGW:  argc = 3'd2;
            OP_TRAP:  argc = 3'd0;
            OP_NOP:   argc = 3'd0;
            default:  op_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/dmar_rptr.sv
module dmar_rptr #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic          empty
);
    assign empty = (rptr == wptr);

    always_ff @(posedge clk) begin
        if (!rst_n)   rptr <= '0;
        else if (adv) rptr <= rptr + 1'b1;
    end
endmodule

// File: rtl/dma_ring_decoder.sv
module dma_ring_decoder
    import dmar_pkg::*;
#(
    parameter int RING_AW = 6,
    parameter int HI_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [RING_AW-1:0]   wptr,
    input  logic                 trap_en,
    input  logic [31:0]          ring_data,
    output logic [RING_AW-1:0]   rptr_wb,
    output logic                 req_valid,
    output logic [1:0]           req_kind,
    output logic [1:0]           req_flags,
    output logic [32+HI_W-1:0]   req_addr,
    output logic [32+HI_W-1:0]   req_src,
    output logic [19:0]          req_len,
    output logic [31:0]          req_data,
    output logic                 reg_wr_valid,
    output logic [3:0]           reg_wr_be,
    output logic [15:0]          reg_wr_off,
    output logic [31:0]          reg_wr_data,
    output logic                 irq,
    output logic [7:0]           irq_code,
    output logic                 error
);
    localparam int CNT_W = 20;
    localparam int PA_W  = 32 + HI_W;

    st_e              st_q, st_d;
    logic [2:0]       idx_q, argc_q;
    logic [3:0]       op_q;
    logic [CNT_W-1:0] cnt_q, left_q;
    logic [1:0]       flg_q;
    logic [31:0]      arg_q [0:2];
    logic [PA_W-1:0]  wa_q;

    logic [3:0]       h_op;
    logic [1:0]       h_flags;
    logic [CNT_W-1:0] h_cnt;
    logic [2:0]       h_argc;
    logic             h_known;
    logic             empty, fetch, bad, advance, last_arg;

    dmar_hdr u_hdr (
        .word(ring_data), .op(h_op), .flags(h_flags),
        .cnt(h_cnt), .argc(h_argc), .known(h_known)
    );

    dmar_rptr #(.AW(RING_AW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .adv(advance),
        .wptr(wptr), .rptr(rptr_wb), .empty(empty)
    );

    assign fetch    = !empty && (st_q != ST_HALT);
    assign advance  = fetch && !bad;
    assign last_arg = (idx_q == argc_q - 3'd1);
    assign error    = (st_q == ST_HALT);

    // malformed-word detection
    always_comb begin
        bad = 1'b0;
        unique case (st_q)
            ST_HDR:  bad = !h_known || (h_op == OP_IB && rptr_wb[2:0] != IB_SLOT);
            ST_ARGS: begin
                if (idx_q == 3'd0 && (op_q == OP_WRITE || op_q == OP_COPY || op_q == OP_FENCE)
                    && ring_data[1:0] != 2'b00) bad = 1'b1;
                if (idx_q == 3'd0 && op_q == OP_IB && ring_data[4:0] != 5'd0) bad = 1'b1;
                if (idx_q == 3'd1 && op_q == OP_COPY && ring_data[1:0] != 2'b00) bad = 1'b1;
            end
            ST_WDATA: bad = 1'b0;
            ST_HALT:  bad = 1'b0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HDR: if (fetch) begin
                if (bad)                 st_d = ST_HALT;
                else if (h_argc != 3'd0) st_d = ST_ARGS;
            end
            ST_ARGS: if (fetch) begin
                if (bad)           st_d = ST_HALT;
                else if (last_arg) st_d = (op_q == OP_WRITE && cnt_q != '0) ? ST_WDATA : ST_HDR;
            end
            ST_WDATA: if (fetch && left_q == CNT_W'(1)) st_d = ST_HDR;
            ST_HALT:  st_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_HDR;
        else        st_q <= st_d;
    end

    // packet context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            argc_q <= '0;
            op_q   <= '0;
            cnt_q  <= '0;
            flg_q  <= '0;
            wa_q   <= '0;
            left_q <= '0;
            for (int i = 0; i < 3; i++) arg_q[i] <= '0;
        end else if (advance) begin
            case (st_q)
                ST_HDR: begin
                    op_q   <= h_op;
                    cnt_q  <= h_cnt;
                    argc_q <= h_argc;
                    flg_q  <= h_flags;
                    idx_q  <= '0;
                end
                ST_ARGS: begin
                    if (!last_arg) arg_q[idx_q[1:0]] <= ring_data;
                    idx_q <= idx_q + 3'd1;
                    if (last_arg && op_q == OP_WRITE) begin
                        wa_q   <= {ring_data[HI_W-1:0], arg_q[0]};
                        left_q <= cnt_q;
                    end
                end
                ST_WDATA: begin
                    wa_q   <= wa_q + PA_W'(4);
                    left_q <= left_q - CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid    <= 1'b0;
            req_kind     <= '0;
            req_flags    <= '0;
            req_addr     <= '0;
            req_src      <= '0;
            req_len      <= '0;
            req_data     <= '0;
            reg_wr_valid <= 1'b0;
            reg_wr_be    <= '0;
            reg_wr_off   <= '0;
            reg_wr_data  <= '0;
            irq          <= 1'b0;
            irq_code     <= '0;
        end else begin
            req_valid    <= 1'b0;
            reg_wr_valid <= 1'b0;
            irq          <= 1'b0;
            if (advance) begin
                case (st_q)
                    ST_HDR: if (h_op == OP_TRAP && trap_en) begin
                        irq      <= 1'b1;
                        irq_code <= TRAP_EVENT;
                    end
                    ST_ARGS: if (last_arg) begin
                        case (op_q)
                            OP_FENCE: begin
                                req_valid <= 1'b1;
                                req_kind  <= RQ_FENCE;
                                req_flags <= flg_q;
                                req_addr  <= {arg_q[1][HI_W-1:0], arg_q[0]};
                                req_src   <= '0;
                                req_len   <= CNT_W'(1);
                                req_data  <= ring_data;
                            end
                            OP_COPY: begin
                                req_valid <= 1'b1;
                                req_kind  <= RQ_COPY;
                                req_flags <= flg_q;
                                req_addr  <= {arg_q[2][HI_W-1:0], arg_q[0]};
                                req_src   <= {ring_data[HI_W-1:0], arg_q[1]};
                                req_len   <= cnt_q;
                                req_data  <= '0;
                            end
                            OP_IB: begin
                                req_valid <= 1'b1;
                                req_kind  <= RQ_IB;
                                req_flags <= flg_q;
                                req_addr  <= {ring_data[HI_W-1:0], arg_q[0]};
                                req_src   <= '0;
                                req_len   <= ring_data[31:12];
                                req_data  <= '0;
                            end
                            OP_REGW: begin
                                reg_wr_valid <= 1'b1;
                                reg_wr_be    <= arg_q[0][19:16];
                                reg_wr_off   <= arg_q[0][15:0];
                                reg_wr_data  <= ring_data;
                            end
                            default: ;
                        endcase
                    end
                    ST_WDATA: begin
                        req_valid <= 1'b1;
                        req_kind  <= RQ_WRITE;
                        req_flags <= flg_q;
                        req_addr  <= wa_q;
                        req_src   <= '0;
                        req_len   <= CNT_W'(1);
                        req_data  <= ring_data;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dmar_chk.sv
module dmar_chk
    import dmar_pkg::*;
#(
    parameter int RING_AW = 6,
    parameter int HI_W    = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [RING_AW-1:0] wptr,
    input logic               trap_en,
    input logic [RING_AW-1:0] rptr_wb,
    input logic               req_valid,
    input logic [1:0]         req_kind,
    input logic [32+HI_W-1:0] req_addr,
    input logic               reg_wr_valid,
    input logic               irq,
    input logic               error
);
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rptr_wb == $past(rptr_wb) || rptr_wb == $past(rptr_wb) + 1'b1));

    p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rptr_wb == wptr) |=> $stable(rptr_wb));

    p_fence_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == RQ_FENCE) |-> (req_addr[1:0] == 2'b00));

    p_ib_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == RQ_IB) |-> (req_addr[4:0] == 5'd0));

    p_trap_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(trap_en));

    p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> (error && $stable(rptr_wb)));

    p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> (!req_valid && !reg_wr_valid && !irq));

    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({req_valid, reg_wr_valid, irq}) <= 1);
endmodule

bind dma_ring_decoder dmar_chk #(.RING_AW(RING_AW), .HI_W(HI_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wptr(wptr), .trap_en(trap_en),
    .rptr_wb(rptr_wb), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .reg_wr_valid(reg_wr_valid), .irq(irq), .error(error)
);

// File: tb/tb_dma_ring_decoder.sv
`timescale 1ns/1ps
module tb_dma_ring_decoder;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] wptr;
    logic          trap_en;
    logic [31:0]   ring_data;
    logic [AW-1:0] rptr_wb;
    logic          req_valid;
    logic [1:0]    req_kind, req_flags;
    logic [39:0]   req_addr, req_src;
    logic [19:0]   req_len;
    logic [31:0]   req_data;
    logic          reg_wr_valid;
    logic [3:0]    reg_wr_be;
    logic [15:0]   reg_wr_off;
    logic [31:0]   reg_wr_data;
    logic          irq;
    logic [7:0]    irq_code;
    logic          error;

    always #2.5 clk = ~clk;

    logic [31:0] ring [0:DEPTH-1];
    assign ring_data = ring[rptr_wb];

    dma_ring_decoder #(.RING_AW(AW), .HI_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .wptr(wptr), .trap_en(trap_en),
        .ring_data(ring_data), .rptr_wb(rptr_wb),
        .req_valid(req_valid), .req_kind(req_kind), .req_flags(req_flags),
        .req_addr(req_addr), .req_src(req_src), .req_len(req_len), .req_data(req_data),
        .reg_wr_valid(reg_wr_valid), .reg_wr_be(reg_wr_be), .reg_wr_off(reg_wr_off),
        .reg_wr_data(reg_wr_data), .irq(irq), .irq_code(irq_code), .error(error)
    );

    typedef struct packed {
        logic [2:0]  k;
        logic [1:0]  f;
        logic [39:0] a;
        logic [39:0] b;
        logic [19:0] len;
        logic [31:0] d;
    } ev_t;

    ev_t   expq[$];
    string tagq[$];
    int    total = 0;
    int    bad   = 0;
    bit    done  = 1'b0;
    logic [AW-1:0] wp;
    int    words = 0;

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic logic [31:0] hdr(logic [3:0] op, logic [19:0] n, logic t, logic s);
        return {op, 4'h0, t, s, 2'b00, n};
    endfunction

    task automatic put(logic [31:0] w);
        ring[wp] = w;
        wp = wp + 1'b1;
        words++;
    endtask

    task automatic expect_ev(ev_t e, string tag);
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    task automatic go();
        wptr = wp;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (rptr_wb == wptr || error) break;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wp = '0;
        wptr = '0;
        words = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // monitor: compare every output event with the scoreboard
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            ev_t obs;
            bit  seen;
            seen = 1'b0;
            obs  = '0;
            if (req_valid) begin
                obs = '{k: {1'b0, req_kind}, f: req_flags, a: req_addr, b: req_src, len: req_len, d: req_data};
                seen = 1'b1;
            end else if (reg_wr_valid) begin
                obs = '{k: 3'd4, f: 2'b00, a: {20'h0, reg_wr_be, reg_wr_off}, b: 40'h0, len: 20'h0, d: reg_wr_data};
                seen = 1'b1;
            end else if (irq) begin
                obs = '{k: 3'd5, f: 2'b00, a: 40'h0, b: 40'h0, len: 20'h0, d: {24'h0, irq_code}};
                seen = 1'b1;
            end
            if (seen) begin
                total++;
                if (expq.size() == 0) begin
                    bad++;
                    $display("FAIL R10 unexpected event act=%h exp=none", obs);
                end else begin
                    ev_t   e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    if (obs !== e) begin
                        bad++;
                        $display("FAIL %s event act=%h exp=%h", t, obs, e);
                    end
                end
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        logic [AW-1:0] hold;
        for (int i = 0; i < DEPTH; i++) ring[i] = 32'hF000_0000;
        trap_en = 1'b0;
        rst_n = 1'b0;
        wp = '0;
        wptr = '0;
        repeat (4) @(negedge clk);
        chk(rptr_wb == '0, "R2", "reset rptr", rptr_wb, 0);
        chk(!error && !req_valid && !reg_wr_valid && !irq, "R10", "reset strobes",
            {error, req_valid, reg_wr_valid, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: NOPs only move the pointer
        put(hdr(4'hF, 20'h0, 1'b0, 1'b0));
        put(hdr(4'hF, 20'h0, 1'b0, 1'b0));
        put(hdr(4'hF, 20'h0, 1'b0, 1'b0));
        go();
        chk(rptr_wb == 3, "R3", "rptr after NOPs", rptr_wb, 3);

        // R4: fence
        put(hdr(4'h6, 20'h0, 1'b0, 1'b0));
        put(32'h1000_0010);
        put(32'h0000_00AB);
        put(32'hDEAD_BEEF);
        expect_ev('{k: 3'd2, f: 2'b00, a: 40'hAB_1000_0010, b: 40'h0, len: 20'd1, d: 32'hDEAD_BEEF}, "R4");
        go();

        // R5: write with three data words, flag bit 23 set
        put(hdr(4'h2, 20'd3, 1'b1, 1'b0));
        put(32'h0000_0200);
        put(32'h0000_0001);
        for (int k = 0; k < 3; k++) begin
            put(32'hC0DE_0000 + k);
            expect_ev('{k: 3'd0, f: 2'b10, a: 40'h01_0000_0200 + 40'(4 * k), b: 40'h0,
                        len: 20'd1, d: 32'hC0DE_0000 + k}, "R5");
        end
        go();

        // R5: write with zero count issues nothing
        hold = rptr_wb;
        put(hdr(4'h2, 20'd0, 1'b0, 1'b0));
        put(32'h0000_0400);
        put(32'h0000_0002);
        go();
        chk(rptr_wb == hold + 3, "R5", "rptr after empty write", rptr_wb, hold + 3);

        // R6: copy, flag bit 22 set
        put(hdr(4'h3, 20'h40, 1'b0, 1'b1));
        put(32'h0000_3000);
        put(32'h0000_4000);
        put(32'h0000_0005);
        put(32'h0000_0006);
        expect_ev('{k: 3'd1, f: 2'b01, a: 40'h05_0000_3000, b: 40'h06_0000_4000, len: 20'h40, d: 32'h0}, "R6");
        go();

        // R8: register write
        put(hdr(4'h9, 20'h0, 1'b0, 1'b0));
        put(32'h000F_1234);
        put(32'h0000_0055);
        expect_ev('{k: 3'd4, f: 2'b00, a: 40'h00_000F_1234, b: 40'h0, len: 20'h0, d: 32'h55}, "R8");
        go();

        // R9: trap with enable low does nothing, then with enable high
        put(hdr(4'h7, 20'h0, 1'b0, 1'b0));
        go();
        chk(expq.size() == 0 && !irq, "R9", "trap disabled", irq, 0);
        trap_en = 1'b1;
        put(hdr(4'h7, 20'h0, 1'b0, 1'b0));
        expect_ev('{k: 3'd5, f: 2'b00, a: 40'h0, b: 40'h0, len: 20'h0, d: 32'd224}, "R9");
        go();
        trap_en = 1'b0;

        // R7: indirect buffer after NOP padding to slot 5 mod 8
        while (wp[2:0] != 3'd5) put(hdr(4'hF, 20'h0, 1'b0, 1'b0));
        put(hdr(4'h4, 20'h0, 1'b0, 1'b0));
        put(32'h0000_8000);
        put({20'h00100, 4'h0, 8'h07});
        expect_ev('{k: 3'd3, f: 2'b00, a: 40'h07_0000_8000, b: 40'h0, len: 20'h100, d: 32'h0}, "R7");
        go();

        // R2: enough traffic to wrap the ring
        for (int p = 0; p < 5; p++) begin
            put(hdr(4'h2, 20'd8, 1'b0, 1'b0));
            put(32'h0001_0000 + 32'(p * 256));
            put(32'h0000_0000);
            for (int k = 0; k < 8; k++) begin
                put(32'(p * 16 + k));
                expect_ev('{k: 3'd0, f: 2'b00, a: 40'h0001_0000 + 40'(p * 256 + 4 * k), b: 40'h0,
                            len: 20'd1, d: 32'(p * 16 + k)}, "R2");
            end
            go();
        end
        chk(words > DEPTH, "R2", "wrap reached", words, DEPTH);
        chk(rptr_wb == AW'(words), "R2", "rptr after wrap", rptr_wb, AW'(words));

        // R2: stall while empty
        hold = rptr_wb;
        repeat (10) @(negedge clk);
        chk(rptr_wb == hold, "R2", "stall when empty", rptr_wb, hold);
        chk(expq.size() == 0, "R2", "queue drained", expq.size(), 0);

        // R1: unknown opcode halts, following fence is never run
        do_reset();
        put(hdr(4'h5, 20'h0, 1'b0, 1'b0));
        put(hdr(4'h6, 20'h0, 1'b0, 1'b0));
        put(32'h0000_0100);
        put(32'h0);
        put(32'h1);
        go();
        chk(error == 1'b1, "R1", "error on opcode 5", error, 1);
        chk(rptr_wb == 0, "R1", "rptr held on bad header", rptr_wb, 0);

        // R7: indirect buffer at wrong slot halts
        do_reset();
        chk(error == 1'b0 && rptr_wb == 0, "R10", "reset clears halt", {error, rptr_wb}, 0);
        put(hdr(4'h4, 20'h0, 1'b0, 1'b0));
        put(32'h0000_8000);
        put(32'h0000_1000);
        go();
        chk(error == 1'b1 && rptr_wb == 0, "R7", "misplaced IB", {error, rptr_wb}, {1'b1, 6'd0});

        // R10: misaligned fence address halts on the operand word
        do_reset();
        put(hdr(4'h6, 20'h0, 1'b0, 1'b0));
        put(32'h0000_1002);
        put(32'h0);
        put(32'h9);
        go();
        chk(error == 1'b1, "R10", "error on misaligned fence", error, 1);
        chk(rptr_wb == 1, "R10", "offending word kept", rptr_wb, 1);
        hold = rptr_wb;
        put(hdr(4'h7, 20'h0, 1'b0, 1'b0));
        trap_en = 1'b1;
        go();
        chk(rptr_wb == hold && error, "R10", "halt sticky", rptr_wb, hold);
        trap_en = 1'b0;

        // R1: reserved header bits set
        do_reset();
        put(32'hF200_0000);
        go();
        chk(error == 1'b1 && rptr_wb == 0, "R1", "reserved bits", {error, rptr_wb}, {1'b1, 6'd0});

        repeat (4) @(negedge clk);
        chk(expq.size() == 0, "R10", "all expected events seen", expq.size(), 0);
        finish_run();
    end
endmodule